// File: doc/BRIEF.md
# Accumulator ALU With Status Flags

This block is the arithmetic and logic datapath of a small 8-bit accumulator machine, together with the three-bit status register that records the outcome of each operation. An accumulator operand and a second operand (taken from memory or an immediate field) enter with a four-bit operation code. The result leaves combinationally in the same cycle. When the operation is marked valid, the status flags update on the next rising clock edge. The incoming carry for carry-chained operations is the carry flag currently held in the status register.

The status register can also be read and written as a byte-wide memory-mapped location. Zero sits in bit 0, nibble carry in bit 1 and carry in bit 2, and the upper bits read as zero. Subtraction uses the not-borrow convention: the carry and nibble-carry flags read 1 when no borrow occurred. Because subtract-with-borrow adds the inverted operand plus the carry flag, multi-byte subtractions chain through the carry flag in the same way additions do.

Top module: `acc_alu`

## Requirements
- R1: After reset the status register reads 0x00, so carry, nibble carry and zero are all clear.
- R2: Add (op_code 0) gives acc_in + opnd_in. Add with carry (op_code 1) gives acc_in + opnd_in + C. Both truncate to 8 bits, and C is set exactly when a carry leaves bit 7.
- R3: Subtract (op_code 2) gives acc_in + ~opnd_in + 1. Subtract with borrow (op_code 3) gives acc_in + ~opnd_in + C. In both, C is set when no borrow occurs and cleared when a borrow occurs.
- R4: For op_codes 0 to 3, the nibble-carry flag N records the carry from bit 3 into bit 4 of the same sum. For subtraction this means N=1 when the low nibbles produce no borrow.
- R5: Rotate left through carry (op_code 7) gives {acc_in[6:0], C} and loads C from acc_in[7]. Rotate right through carry (op_code 8) gives {C, acc_in[7:1]} and loads C from acc_in[0]. Both leave N unchanged.
- R6: For every op_code from 0 to 8, the zero flag Z is set exactly when the 8-bit result is zero.
- R7: AND (op_code 4), OR (op_code 5) and XOR (op_code 6) give the bitwise result and update only Z. C and N keep their values.
- R8: flag_rdata presents Z in bit 0, N in bit 1 and C in bit 2, with bits 7 to 3 reading 0. A write with flag_we loads bits 2 to 0 of flag_wdata into those positions and ignores bits 7 to 3.
- R9: When flag_we and op_valid are both high in the same cycle, the written value is stored and the operation's flag update is discarded.
- R10: With op_valid low and flag_we low, the flags hold. Op_codes 9 to 15 pass acc_in to result and leave the flags unchanged even when op_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Commit this cycle's flag update |
| op_code | input | 4 | Operation select (encodings in R2 to R7, R10) |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Memory or immediate operand |
| result | output | 8 | Combinational operation result |
| flag_we | input | 1 | Direct write strobe for the status register |
| flag_wdata | input | 8 | Direct write data |
| flag_rdata | output | 8 | Status register read value |

## Verification
A wrong flag state is invisible on `result` until it is consumed. It becomes visible there in the same cycle that a carry-consuming operation (add with carry, subtract with borrow or a rotate) is issued. On `flag_rdata` it shows one clock after the offending commit. The bench therefore seeds C with a direct write before every chained operation, and reads the status byte one edge after each commit. It also checks that C and N survive logic operations and rotates. A broken write-priority path shows on the first cycle in which a write and an operation collide.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_RLC = 4'd7,
    OP_RRC = 4'd8
  } alu_op_e;

  localparam int FLAG_W = 3;
  localparam int FLG_Z  = 0;
  localparam int FLG_N  = 1;
  localparam int FLG_C  = 2;
endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith #(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic              invert_b,
  output logic [DATA_W-1:0] sum,
  output logic              carry_out,
  output logic              nib_carry
);
  function automatic logic [DATA_W:0] full_add(
    input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y, input logic c);
    full_add = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, c};
  endfunction

  function automatic logic [NIB_W:0] low_add(
    input logic [NIB_W-1:0] x, input logic [NIB_W-1:0] y, input logic c);
    low_add = {1'b0, x} + {1'b0, y} + {{NIB_W{1'b0}}, c};
  endfunction

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   wide;
  logic [NIB_W:0]    low;

  assign b_eff     = invert_b ? ~b : b;
  assign wide      = full_add(a, b_eff, cin);
  assign low       = low_add(a[NIB_W-1:0], b_eff[NIB_W-1:0], cin);
  assign sum       = wide[DATA_W-1:0];
  assign carry_out = wide[DATA_W];
  assign nib_carry = low[NIB_W];
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
  parameter int DATA_W = 8
) (
  input  acc_alu_pkg::alu_op_e op,
  input  logic [DATA_W-1:0]    a,
  input  logic [DATA_W-1:0]    b,
  input  logic                 cin,
  output logic [DATA_W-1:0]    res,
  output logic                 shift_out
);
  import acc_alu_pkg::*;

  always_comb begin
    res       = a;
    shift_out = cin;
    case (op)
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_RLC: begin
        res       = {a[DATA_W-2:0], cin};
        shift_out = a[DATA_W-1];
      end
      OP_RRC: begin
        res       = {cin, a[DATA_W-1:1]};
        shift_out = a[0];
      end
      default: res = a;
    endcase
  end
endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd_z,
  input  logic       upd_n,
  input  logic       upd_c,
  input  logic       new_z,
  input  logic       new_n,
  input  logic       new_c,
  input  logic       wr_en,
  input  logic [2:0] wr_data,
  output logic       z_q,
  output logic       n_q,
  output logic       c_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z_q <= 1'b0;
      n_q <= 1'b0;
      c_q <= 1'b0;
    end else if (wr_en) begin
      z_q <= wr_data[0];
      n_q <= wr_data[1];
      c_q <= wr_data[2];
    end else begin
      if (upd_z) z_q <= new_z;
      if (upd_n) n_q <= new_n;
      if (upd_c) c_q <= new_c;
    end
  end

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> {c_q, n_q, z_q} == $past(wr_data)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !upd_z && !upd_n && !upd_c) |=> $stable({c_q, n_q, z_q})); // R10
  AST_NIB_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !upd_n) |=> $stable(n_q)); // R7
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] opnd_in,
  output logic [DATA_W-1:0] result,
  input  logic              flag_we,
  input  logic [DATA_W-1:0] flag_wdata,
  output logic [DATA_W-1:0] flag_rdata
);
  import acc_alu_pkg::*;

  localparam int PAD_W = DATA_W - FLAG_W;

  alu_op_e op;
  logic z_q, n_q, c_q;
  logic is_arith, is_logic, is_rot, is_known;
  logic use_flag_cin, arith_cin, invert_b;
  logic [DATA_W-1:0] arith_sum, logic_res;
  logic arith_cout, arith_ncout, rot_out;
  logic upd_z, upd_n, upd_c, new_c;
  logic unused_wdata;

  assign op = alu_op_e'(op_code);

  assign is_arith = (op_code <= 4'd3);
  assign is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  assign is_rot   = (op == OP_RLC) || (op == OP_RRC);
  assign is_known = is_arith || is_logic || is_rot;

  assign invert_b     = (op == OP_SUB) || (op == OP_SBB);
  assign use_flag_cin = (op == OP_ADC) || (op == OP_SBB);
  assign arith_cin    = use_flag_cin ? c_q : (op == OP_SUB);

  acc_alu_arith #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_arith (
    .a(acc_in), .b(opnd_in), .cin(arith_cin), .invert_b(invert_b),
    .sum(arith_sum), .carry_out(arith_cout), .nib_carry(arith_ncout)
  );

  acc_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .op(op), .a(acc_in), .b(opnd_in), .cin(c_q),
    .res(logic_res), .shift_out(rot_out)
  );

  assign result = is_arith ? arith_sum : logic_res;

  assign upd_z = op_valid && is_known;
  assign upd_n = op_valid && is_arith;
  assign upd_c = op_valid && (is_arith || is_rot);
  assign new_c = is_arith ? arith_cout : rot_out;

  acc_alu_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .upd_z(upd_z), .upd_n(upd_n), .upd_c(upd_c),
    .new_z(result == '0), .new_n(arith_ncout), .new_c(new_c),
    .wr_en(flag_we), .wr_data(flag_wdata[FLAG_W-1:0]),
    .z_q(z_q), .n_q(n_q), .c_q(c_q)
  );

  assign flag_rdata   = {{PAD_W{1'b0}}, c_q, n_q, z_q};
  assign unused_wdata = ^flag_wdata[DATA_W-1:FLAG_W];

  AST_ZERO_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !flag_we && is_known) |=> flag_rdata[FLG_Z] == ($past(result) == '0)); // R6
  AST_ROT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !flag_we && op == OP_RLC) |=> flag_rdata[FLG_C] == $past(acc_in[DATA_W-1])); // R5
  AST_SUB_NOBORROW: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !flag_we && op == OP_SUB) |=> flag_rdata[FLG_C] == ($past(acc_in) >= $past(opnd_in))); // R3
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rdata[DATA_W-1:FLAG_W] == '0); // R8
endmodule

// File: tb/sim_acc_alu.sv
`timescale 1ns/1ps
module sim_acc_alu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [3:0] op_code = 4'd0;
  logic [7:0] acc_in = 8'd0, opnd_in = 8'd0, flag_wdata = 8'd0;
  logic flag_we = 1'b0;
  logic [7:0] result, flag_rdata;
  int total = 0, bad = 0;
  bit done = 0;
  bit mc, mn, mz;

  always #2 clk = ~clk;

  acc_alu u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .acc_in(acc_in), .opnd_in(opnd_in), .result(result),
    .flag_we(flag_we), .flag_wdata(flag_wdata), .flag_rdata(flag_rdata)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int flag_byte();
    return (int'(mc) << 2) | (int'(mn) << 1) | int'(mz);
  endfunction

  task automatic set_flags(input int v);
    @(negedge clk);
    flag_we = 1'b1; flag_wdata = v[7:0];
    @(negedge clk);
    flag_we = 1'b0;
    mz = v[0]; mn = v[1]; mc = v[2];
  endtask

  // reference model built from the requirement text
  task automatic model(input int op, input int a, input int b, output int r, output bit ok);
    int s, lo, cin;
    ok = 1;
    case (op)
      0, 1: begin
        cin = (op == 1) ? int'(mc) : 0;
        s = a + b + cin; lo = (a % 16) + (b % 16) + cin;
        r = s % 256; mc = (s > 255); mn = (lo > 15);
      end
      2, 3: begin
        cin = (op == 3) ? int'(mc) : 1;
        s = a - b - (1 - cin); lo = (a % 16) - (b % 16) - (1 - cin);
        r = (s + 256) % 256; mc = (s >= 0); mn = (lo >= 0);
      end
      4: r = a & b;
      5: r = a | b;
      6: r = a ^ b;
      7: begin r = ((a * 2) % 256) + int'(mc); mc = (a >= 128); end
      8: begin r = (a / 2) + (mc ? 128 : 0); mc = (a % 2 == 1); end
      default: begin r = a; ok = 0; end
    endcase
    if (ok) mz = (r == 0);
  endtask

  task automatic run_op(input string tag, input int op, input int a, input int b);
    int r; bit ok;
    @(negedge clk);
    op_valid = 1'b1; op_code = op[3:0]; acc_in = a[7:0]; opnd_in = b[7:0];
    model(op, a, b, r, ok);
    #1 chk({tag, " result"}, result, r);
    @(negedge clk);
    op_valid = 1'b0;
    #1 chk({tag, " flags"}, flag_rdata, flag_byte());
  endtask

  task automatic t_reset();
    chk("R1 reset flags", flag_rdata, 0);
  endtask

  task automatic t_add();
    set_flags(0);
    run_op("R2 add carry out", 0, 8'hC8, 8'h64);
    run_op("R2 adc uses C", 1, 8'h10, 8'h20);
    run_op("R2 add no carry", 0, 8'h12, 8'h34);
    set_flags(4);
    run_op("R2 adc wrap", 1, 8'hFF, 8'h00);
  endtask

  task automatic t_sub();
    set_flags(0);
    run_op("R3 sub no borrow", 2, 8'h50, 8'h20);
    run_op("R3 sub borrow", 2, 8'h20, 8'h50);
    set_flags(0);
    run_op("R3 sbb borrow in", 3, 8'h50, 8'h20);
    set_flags(4);
    run_op("R3 sbb no borrow in", 3, 8'h00, 8'h00);
  endtask

  task automatic t_nibble();
    set_flags(0);
    run_op("R4 add nibble carry", 0, 8'h0F, 8'h01);
    run_op("R4 sub nibble borrow", 2, 8'h10, 8'h01);
    run_op("R4 sub nibble ok", 2, 8'h1F, 8'h0E);
  endtask

  task automatic t_rotate();
    set_flags(2);
    run_op("R5 rlc C=0", 7, 8'h81, 0);
    run_op("R5 rlc C=1", 7, 8'h40, 0);
    run_op("R5 rrc", 8, 8'h01, 0);
    run_op("R5 rrc C in", 8, 8'h02, 0);
  endtask

  task automatic t_zero();
    set_flags(0);
    run_op("R6 add to zero", 0, 8'hFF, 8'h01);
    run_op("R6 sub equal", 2, 8'h33, 8'h33);
    set_flags(0);
    run_op("R6 rrc zero", 8, 8'h01, 0);
  endtask

  task automatic t_logic();
    set_flags(6);
    run_op("R7 and", 4, 8'hF0, 8'h3C);
    run_op("R7 or", 5, 8'h00, 8'h00);
    run_op("R7 xor", 6, 8'hAA, 8'h55);
  endtask

  task automatic t_status();
    set_flags(8'hF9);
    chk("R8 write layout", flag_rdata, 8'h01);
    set_flags(8'h06);
    chk("R8 write C N", flag_rdata, 8'h06);
  endtask

  task automatic t_collision();
    set_flags(0);
    @(negedge clk);
    op_valid = 1'b1; op_code = 4'd0; acc_in = 8'hFF; opnd_in = 8'h01;
    flag_we = 1'b1; flag_wdata = 8'h02;
    @(negedge clk);
    op_valid = 1'b0; flag_we = 1'b0;
    mz = 0; mn = 1; mc = 0;
    #1 chk("R9 write beats op", flag_rdata, 8'h02);
  endtask

  task automatic t_hold();
    set_flags(5);
    @(negedge clk);
    op_valid = 1'b0; op_code = 4'd0; acc_in = 8'hFF; opnd_in = 8'hFF;
    @(negedge clk);
    #1 chk("R10 idle hold", flag_rdata, 8'h05);
    run_op("R10 unused op 9", 9, 8'h5A, 8'hFF);
    run_op("R10 unused op 15", 15, 8'h00, 8'h00);
  endtask

  initial begin
    mc = 0; mn = 0; mz = 0;
    #9 rst_n = 1'b1;
    @(negedge clk);
    #1 t_reset();
    t_add();
    t_sub();
    t_nibble();
    t_rotate();
    t_zero();
    t_logic();
    t_status();
    t_collision();
    t_hold();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule